// File: doc/BRIEF.md
# SHA-512 Two-Round Sigma1/Choose Unit

This block is a pipelined datapath that computes the Sigma1 and Choose contributions of two consecutive SHA-512 compression rounds in one operation. It takes three 128-bit operands, X, Y and W, each seen as a high 64-bit lane and a low 64-bit lane. It returns a 128-bit result that takes the place of W in the surrounding datapath. The high result lane is formed first. An intermediate sum t, which is that high lane plus the low lane of Y, then drives the second round. That second round produces the low result lane.

Operands arrive with a valid strobe and the result leaves with a valid strobe exactly two cycles later. Latency never depends on the data. There is no backpressure, and a new operation may start every cycle. A separate combinational path checks a 32-bit instruction word against the fixed opcode pattern of this operation and extracts the three 5-bit register indices. The surrounding core uses these indices to read X, Y and W from its register file.

Top module: `sha512_sig1ch_pair`

## Requirements
- R1: For a valid operation, out_res[127:64] = Ch1 + S(Y[127:64]) + W[127:64]. Here S(v) is the XOR of v rotated right by 14, 18 and 41 bits. Ch1 takes each bit from X[63:0] where Y[127:64] has a 1 and from X[127:64] where it has a 0.
- R2: With t = out_res[127:64] + Y[63:0], out_res[63:0] = Ch2 + S(t) + W[63:0]. Ch2 takes each bit from Y[127:64] where t has a 1 and from X[63:0] where t has a 0.
- R3: Every addition is modulo 2^64: carries out of bit 63 of either lane are dropped and never reach the other lane.
- R4: out_valid is high exactly when in_valid was high two clock cycles earlier. Operations issued on consecutive cycles each produce their own result, in issue order, with no stall.
- R5: A synchronous active-high rst forces out_valid low on the following edge. An operation still in flight when rst is applied produces no result.
- R6: insn_ok is high only when insn[31:21] = 11001110011 and insn[15:10] = 100000. When it is high, idx_m = insn[20:16], idx_n = insn[9:5] and idx_d = insn[4:0].
- R7: When insn_ok is low, idx_m, idx_n and idx_d are all zero.
- R8: The decode outputs follow insn within the same cycle, whatever the state of the hash pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Operands present this cycle |
| in_x | input | 128 | Operand X (two 64-bit lanes) |
| in_y | input | 128 | Operand Y (two 64-bit lanes) |
| in_w | input | 128 | Operand W (two 64-bit lanes), the accumulator |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 128 | Two-round result, high lane then low lane |
| insn | input | 32 | Instruction word to decode |
| insn_ok | output | 1 | Instruction word matches the operation's opcode |
| idx_m | output | 5 | Register index of the Y operand |
| idx_n | output | 5 | Register index of the X operand |
| idx_d | output | 5 | Register index of W and of the result |

## Verification
Two pairs of functions can share a cycle. In the first, the hash pipeline returns the result of one operation while it accepts the next, and the instruction decoder resolves a word in that same cycle. The bench provokes both by streaming operations on consecutive cycles and by putting a fresh matching or corrupted instruction word on insn with every issue. In each cycle a scoreboard monitor compares the returned lane pair with the oldest queued model value, checks out_valid against the valid history two cycles back, and checks the decode outputs against a field model of the current word.

// File: rtl/s2r_pkg.sv
package s2r_pkg;
   localparam int unsigned INSN_W   = 32;
   localparam int unsigned IDX_W    = 5;
   localparam logic [10:0] OPC_TOP  = 11'b11001110011;
   localparam logic [5:0]  OPC_MID  = 6'b100000;

   typedef struct packed {
      logic [IDX_W-1:0] src_y;
      logic [IDX_W-1:0] src_x;
      logic [IDX_W-1:0] dst_w;
   } reg_idx_t;

   typedef enum logic {
      ADD_RIPPLE3 = 1'b0,
      ADD_CSA     = 1'b1
   } add_style_e;
endpackage

// File: rtl/s2r_round_mix.sv
module s2r_round_mix
   import s2r_pkg::*;
#(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned ROT_A  = 14,
   parameter int unsigned ROT_B  = 18,
   parameter int unsigned ROT_C  = 41,
   parameter add_style_e  STYLE  = ADD_CSA
) (
   input  logic [LANE_W-1:0] sel_i,
   input  logic [LANE_W-1:0] take1_i,
   input  logic [LANE_W-1:0] take0_i,
   input  logic [LANE_W-1:0] acc_i,
   output logic [LANE_W-1:0] sum_o
);
   localparam int unsigned RA_L = LANE_W - ROT_A;
   localparam int unsigned RB_L = LANE_W - ROT_B;
   localparam int unsigned RC_L = LANE_W - ROT_C;

   logic [LANE_W-1:0] pick_v;
   logic [LANE_W-1:0] sig_v;

   // bitwise choose: selector 1 takes take1, selector 0 takes take0
   assign pick_v = (sel_i & take1_i) | (~sel_i & take0_i);
   assign sig_v  = ((sel_i >> ROT_A) | (sel_i << RA_L))
                 ^ ((sel_i >> ROT_B) | (sel_i << RB_L))
                 ^ ((sel_i >> ROT_C) | (sel_i << RC_L));

   generate
      if (STYLE == ADD_CSA) begin : g_csa
         logic [LANE_W-1:0] part_s;
         logic [LANE_W-1:0] part_m;
         logic [LANE_W-1:0] part_c;
         assign part_s = pick_v ^ sig_v ^ acc_i;
         assign part_m = (pick_v & sig_v) | (pick_v & acc_i) | (sig_v & acc_i);
         assign part_c = part_m << 1;
         assign sum_o  = part_s + part_c;
      end else begin : g_ripple
         assign sum_o = pick_v + sig_v + acc_i;
      end
   endgenerate
endmodule

// File: rtl/s2r_insn_decode.sv
module s2r_insn_decode
   import s2r_pkg::*;
#(
   parameter bit DEC_EN = 1'b1
) (
   input  logic [INSN_W-1:0] word_i,
   output logic              hit_o,
   output reg_idx_t          idx_o
);
   generate
      if (DEC_EN) begin : g_dec
         logic match_v;
         assign match_v = (word_i[31:21] == OPC_TOP) && (word_i[15:10] == OPC_MID);
         assign hit_o   = match_v;
         always_comb begin
            idx_o = '0;
            if (match_v) begin
               idx_o.src_y = word_i[20:16];
               idx_o.src_x = word_i[9:5];
               idx_o.dst_w = word_i[4:0];
            end
         end
      end else begin : g_nodec
         logic unused_w;
         assign unused_w = ^word_i;
         assign hit_o    = 1'b0;
         assign idx_o    = '0;
      end
   endgenerate
endmodule

// File: rtl/sha512_sig1ch_pair.sv
module sha512_sig1ch_pair
   import s2r_pkg::*;
#(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned ROT_A  = 14,
   parameter int unsigned ROT_B  = 18,
   parameter int unsigned ROT_C  = 41,
   parameter add_style_e  STYLE  = ADD_CSA,
   parameter bit          DEC_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [2*LANE_W-1:0]   in_x,
   input  logic [2*LANE_W-1:0]   in_y,
   input  logic [2*LANE_W-1:0]   in_w,
   output logic                  out_valid,
   output logic [2*LANE_W-1:0]   out_res,
   input  logic [31:0]           insn,
   output logic                  insn_ok,
   output logic [4:0]            idx_m,
   output logic [4:0]            idx_n,
   output logic [4:0]            idx_d
);
   localparam int unsigned OP_W = 2 * LANE_W;
   localparam int unsigned HI_L = LANE_W;

   generate
      if (LANE_W < 2) begin : g_bad_w
         $error("LANE_W must be at least 2");
      end
      if (ROT_A == 0 || ROT_A >= LANE_W || ROT_B == 0 || ROT_B >= LANE_W ||
          ROT_C == 0 || ROT_C >= LANE_W) begin : g_bad_rot
         $error("rotation amounts must lie in 1..LANE_W-1");
      end
   endgenerate

   // operand lane split
   logic [LANE_W-1:0] x_hi, x_lo, y_hi, y_lo, w_hi, w_lo;
   assign x_hi = in_x[OP_W-1:HI_L];
   assign x_lo = in_x[LANE_W-1:0];
   assign y_hi = in_y[OP_W-1:HI_L];
   assign y_lo = in_y[LANE_W-1:0];
   assign w_hi = in_w[OP_W-1:HI_L];
   assign w_lo = in_w[LANE_W-1:0];

   // stage 1: first round lane and chained selector
   logic [LANE_W-1:0] hi_comb;
   logic [LANE_W-1:0] t_comb;

   s2r_round_mix #(
      .LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C), .STYLE(STYLE)
   ) u_rnd_a (
      .sel_i  (y_hi),
      .take1_i(x_lo),
      .take0_i(x_hi),
      .acc_i  (w_hi),
      .sum_o  (hi_comb)
   );

   assign t_comb = hi_comb + y_lo;

   logic              s1_vld;
   logic [LANE_W-1:0] s1_hi, s1_t, s1_yhi, s1_xlo, s1_wlo;

   always_ff @(posedge clk) begin
      if (rst) s1_vld <= 1'b0;
      else     s1_vld <= in_valid;
   end

   always_ff @(posedge clk) begin
      s1_hi  <= hi_comb;
      s1_t   <= t_comb;
      s1_yhi <= y_hi;
      s1_xlo <= x_lo;
      s1_wlo <= w_lo;
   end

   // stage 2: second round lane
   logic [LANE_W-1:0] lo_comb;

   s2r_round_mix #(
      .LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C), .STYLE(STYLE)
   ) u_rnd_b (
      .sel_i  (s1_t),
      .take1_i(s1_yhi),
      .take0_i(s1_xlo),
      .acc_i  (s1_wlo),
      .sum_o  (lo_comb)
   );

   logic              s2_vld;
   logic [OP_W-1:0]   s2_res;

   always_ff @(posedge clk) begin
      if (rst) s2_vld <= 1'b0;
      else     s2_vld <= s1_vld;
   end

   always_ff @(posedge clk) begin
      s2_res <= {s1_hi, lo_comb};
   end

   assign out_valid = s2_vld;
   assign out_res   = s2_res;

   // instruction decode path
   reg_idx_t dec_idx;

   s2r_insn_decode #(.DEC_EN(DEC_EN)) u_dec (
      .word_i(insn),
      .hit_o (insn_ok),
      .idx_o (dec_idx)
   );

   assign idx_m = dec_idx.src_y;
   assign idx_n = dec_idx.src_x;
   assign idx_d = dec_idx.dst_w;
endmodule

// File: rtl/s2r_pair_chk.sv
module s2r_pair_chk #(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned ROT_A  = 14,
   parameter int unsigned ROT_B  = 18,
   parameter int unsigned ROT_C  = 41
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [2*LANE_W-1:0] in_x,
   input logic [2*LANE_W-1:0] in_y,
   input logic [2*LANE_W-1:0] in_w,
   input logic                out_valid,
   input logic [2*LANE_W-1:0] out_res,
   input logic [31:0]         insn,
   input logic                insn_ok,
   input logic [4:0]          idx_m,
   input logic [4:0]          idx_n,
   input logic [4:0]          idx_d
);
   localparam int unsigned OP_W = 2 * LANE_W;

   function automatic logic [LANE_W-1:0] rr(input logic [LANE_W-1:0] v, input int unsigned k);
      return (v >> k) | (v << (LANE_W - k));
   endfunction

   function automatic logic [LANE_W-1:0] big_s(input logic [LANE_W-1:0] v);
      return rr(v, ROT_A) ^ rr(v, ROT_B) ^ rr(v, ROT_C);
   endfunction

   function automatic logic [OP_W-1:0] ref_pair(input logic [OP_W-1:0] x,
                                                input logic [OP_W-1:0] y,
                                                input logic [OP_W-1:0] w);
      logic [LANE_W-1:0] h, t, l;
      h = ((y[OP_W-1:LANE_W] & x[LANE_W-1:0]) | (~y[OP_W-1:LANE_W] & x[OP_W-1:LANE_W]))
        + big_s(y[OP_W-1:LANE_W]) + w[OP_W-1:LANE_W];
      t = h + y[LANE_W-1:0];
      l = ((t & y[OP_W-1:LANE_W]) | (~t & x[LANE_W-1:0])) + big_s(t) + w[LANE_W-1:0];
      return {h, l};
   endfunction

   p_lat_on_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ##1 out_valid);

   p_lat_off_r4: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ##1 !out_valid);

   p_rst_clear_r5: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R1, R2, R3: both lanes against a port-level model two cycles back
   p_lanes_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ##1 (out_res == ref_pair($past(in_x, 2), $past(in_y, 2), $past(in_w, 2))));

   p_dec_fields_r6: assert property (@(posedge clk) disable iff (rst)
      insn_ok |-> (idx_m == insn[20:16] && idx_n == insn[9:5] && idx_d == insn[4:0]
                   && insn[31:21] == 11'b11001110011 && insn[15:10] == 6'b100000));

   p_dec_zero_r7: assert property (@(posedge clk) disable iff (rst)
      !insn_ok |-> (idx_m == 5'd0 && idx_n == 5'd0 && idx_d == 5'd0));
endmodule

bind sha512_sig1ch_pair s2r_pair_chk #(
   .LANE_W(LANE_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_w(in_w),
   .out_valid(out_valid), .out_res(out_res), .insn(insn), .insn_ok(insn_ok),
   .idx_m(idx_m), .idx_n(idx_n), .idx_d(idx_d)
);

// File: tb/sha512_sig1ch_pair_tb.sv
module sha512_sig1ch_pair_tb;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [127:0] in_x = '0, in_y = '0, in_w = '0;
   logic         out_valid;
   logic [127:0] out_res;
   logic [31:0]  insn = '0;
   logic         insn_ok;
   logic [4:0]   idx_m, idx_n, idx_d;

   int unsigned errors = 0;
   int unsigned checks = 0;
   logic [127:0] exp_q[$];
   logic         h0 = 1'b0, h1 = 1'b0;

   always #2 clk = ~clk;

   sha512_sig1ch_pair u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_w(in_w),
      .out_valid(out_valid), .out_res(out_res), .insn(insn), .insn_ok(insn_ok),
      .idx_m(idx_m), .idx_n(idx_n), .idx_d(idx_d)
   );

   function automatic logic [63:0] ror(input logic [63:0] v, input int k);
      return (v >> k) | (v << (64 - k));
   endfunction

   function automatic logic [63:0] sg(input logic [63:0] v);
      return ror(v, 14) ^ ror(v, 18) ^ ror(v, 41);
   endfunction

   function automatic logic [127:0] model(input logic [127:0] x, y, w);
      logic [63:0] xh, xl, yh, yl, hh, tt, ll;
      xh = x[127:64]; xl = x[63:0]; yh = y[127:64]; yl = y[63:0];
      hh = 64'd0;
      for (int b = 0; b < 64; b++) hh[b] = yh[b] ? xl[b] : xh[b];
      hh = hh + sg(yh) + w[127:64];
      tt = hh + yl;
      ll = 64'd0;
      for (int b = 0; b < 64; b++) ll[b] = tt[b] ? yh[b] : xl[b];
      ll = ll + sg(tt) + w[63:0];
      return {hh, ll};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: valid history, result lanes, decode fields
   always @(negedge clk) begin
      logic        e_ok;
      logic [14:0] e_idx;
      if (rst) begin
         chk(out_valid == 1'b0, "R5 out_valid low in reset", {127'd0, out_valid}, 128'd0);
         exp_q.delete();
         h0 = 1'b0; h1 = 1'b0;
      end else begin
         // R4: out_valid mirrors in_valid two cycles back
         chk(out_valid == h1, "R4 valid latency", {127'd0, out_valid}, {127'd0, h1});
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected result", out_res, 128'd0);
            end else begin
               logic [127:0] e;
               e = exp_q.pop_front();
               chk(out_res[127:64] == e[127:64], "R1 high lane", {64'd0, out_res[127:64]}, {64'd0, e[127:64]});
               chk(out_res[63:0] == e[63:0], "R2 low lane", {64'd0, out_res[63:0]}, {64'd0, e[63:0]});
            end
         end
         h1 = h0;
         h0 = in_valid;
      end
      // R6, R7, R8: decode evaluated in the same cycle as the pipeline
      e_ok  = (insn[31:21] == 11'b11001110011) && (insn[15:10] == 6'b100000);
      e_idx = e_ok ? {insn[20:16], insn[9:5], insn[4:0]} : 15'd0;
      chk(insn_ok == e_ok, e_ok ? "R6 decode accept" : "R7 decode reject",
          {127'd0, insn_ok}, {127'd0, e_ok});
      chk({idx_m, idx_n, idx_d} == e_idx, e_ok ? "R6 index fields" : "R7 zero indices R8",
          {113'd0, idx_m, idx_n, idx_d}, {113'd0, e_idx});
   end

   function automatic logic [31:0] mk_insn(input int kind);
      logic [4:0] m, n, d;
      m = 5'($urandom); n = 5'($urandom); d = 5'($urandom);
      case (kind)
         0: return {11'b11001110011, m, 6'b100000, n, d};
         1: return {11'b11001110011 ^ (11'd1 << ($urandom % 11)), m, 6'b100000, n, d};
         2: return {11'b11001110011, m, 6'b100000 ^ (6'd1 << ($urandom % 6)), n, d};
         default: return $urandom;
      endcase
   endfunction

   // driver: one cycle per call, pushes the expected result when valid
   task automatic issue(input bit v, input logic [127:0] x, y, w);
      @(posedge clk);
      #1;
      in_valid = v;
      in_x = x; in_y = y; in_w = w;
      insn = mk_insn($urandom % 4);
      if (v) exp_q.push_back(model(x, y, w));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [127:0] ones, alt_a, alt_b;
      ones  = '1;
      alt_a = {4{32'hAAAAAAAA}};
      alt_b = {4{32'h55555555}};
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      // corner operands back to back (R1, R2, R3 wrap with all ones)
      issue(1, '0, '0, '0);
      issue(1, ones, ones, ones);
      issue(1, alt_a, alt_b, alt_a);
      issue(1, alt_b, alt_a, ones);
      issue(1, {64'h0, 64'hFFFFFFFFFFFFFFFF}, {64'hFFFFFFFFFFFFFFFF, 64'h1}, {64'hFFFFFFFFFFFFFFFF, 64'h0});
      issue(1, {64'hFFFFFFFFFFFFFFFF, 64'h0}, {64'h0, 64'hFFFFFFFFFFFFFFFF}, {64'h0, 64'hFFFFFFFFFFFFFFFF});
      issue(0, '0, '0, '0);
      // random stream with gaps (R4 ordering)
      for (int i = 0; i < 300; i++) begin
         issue(($urandom % 4) != 0,
               {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom});
      end
      // R5: operation in flight when reset arrives is dropped
      repeat (3) issue(0, '0, '0, '0);
      issue(1, ones, alt_a, alt_b);
      @(posedge clk);
      #1 rst = 1'b1; in_valid = 1'b0;
      @(posedge clk);
      #1 rst = 1'b0;
      repeat (4) issue(0, '0, '0, '0);
      // resume after reset
      for (int i = 0; i < 20; i++) begin
         issue(1, {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom});
      end
      repeat (4) issue(0, '0, '0, '0);
      chk(exp_q.size() == 0, "R4 all results returned", 128'(exp_q.size()), 128'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule